// File: doc/BRIEF.md
# Feedback Divider Glide Sequencer

This block moves a PLL's feedback multiplier from its present value to a new one while the loop stays locked. It does not reprogram the PLL from scratch. It drives the PLL's own gradual-change hardware: it loads the two step-rate fields, puts the PLL into its slow-change mode, presents the new multiplier with a one-cycle write strobe, and then raises the gradual-change enable. After that it watches a completion flag, which the PLL supplies already synchronized to this clock domain.

The flag is sampled at a fixed spacing, `POLL_INTERVAL` cycles apart, and at most `MAX_POLLS` times. The defaults give one sample per microsecond at 125 MHz and 500 samples in all. The block leaves slow-change mode on both paths: when the PLL reports completion, and when the sample budget runs out. It drops the slow-change enable and the gradual-change enable in the same cycle. It then pulses `done_o` for one cycle, and `timeout_o` rises alongside it if the budget ran out.

If the requested multiplier already equals the present one, the block finishes at once and touches nothing. All ports are plain control and status pins. A start request is taken only when the block is idle. There is no back-pressure: a start pulse that arrives while busy is dropped.

Top module: `ndiv_glide_ctrl`

## Requirements
- R1: When `start_i` is sampled while idle and `target_n_i` equals `cur_n_i`, `done_o` is high in the very next cycle. No write strobe, slow-change enable or gradual-change enable appears, and `timeout_o` stays low.
- R2: Whenever `slow_en_o` is high, `step_a_o` holds 0x2B and `step_b_o` holds 0x0B, each in an 8-bit field.
- R3: The order of events is fixed: the step fields are loaded, then `slow_en_o` rises, then `n_wr_o` pulses while `slow_en_o` is high and `ramp_en_o` is low, and `ramp_en_o` rises in the cycle after that pulse.
- R4: `n_wr_o` is high for exactly one cycle per accepted glide. At that moment `n_val_o` carries the target captured at start.
- R5: The completion flag is sampled once every `POLL_INTERVAL` cycles while `ramp_en_o` is high. The first sample falls `POLL_INTERVAL` cycles after the gradual-change phase is entered, and there are never more than `MAX_POLLS` samples.
- R6: If sample j (1-based) sees `ramp_done_i` high, `done_o` rises 5 + j·`POLL_INTERVAL` cycles after the start edge, and `timeout_o` stays low.
- R7: `slow_en_o` and `ramp_en_o` fall in the same cycle, and both are low when `done_o` is high.
- R8: If all `MAX_POLLS` samples see the flag low, `done_o` and `timeout_o` rise together 5 + `MAX_POLLS`·`POLL_INTERVAL` cycles after the start edge. `timeout_o` is never high without `done_o`.
- R9: A `start_i` pulse while `busy_o` is high is ignored: no second write strobe, no change of `n_val_o`, and no extra `done_o`.
- R10: `done_o` is a single-cycle pulse.
- R11: After reset every output is low, and the step fields read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a glide; sampled only when idle |
| target_n_i | input | N_W | Requested feedback multiplier |
| cur_n_i | input | N_W | Multiplier presently programmed |
| ramp_done_i | input | 1 | Synchronized completion flag from the PLL |
| step_a_o | output | STEP_W | First step-rate field |
| step_b_o | output | STEP_W | Second step-rate field |
| slow_en_o | output | 1 | Slow-change mode enable |
| ramp_en_o | output | 1 | Gradual-change enable |
| n_wr_o | output | 1 | One-cycle multiplier write strobe |
| n_val_o | output | N_W | Multiplier value for the write |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Sample budget exhausted; valid with `done_o` |
| busy_o | output | 1 | A glide is in progress |

## Verification
The embedded properties assume that `ramp_done_i` is already synchronous to `clk`, and that the PLL raises it only while `ramp_en_o` is high. The bench's PLL model respects this: it asserts the flag a chosen number of cycles after the gradual-change enable rises and clears it as soon as that enable drops. The properties also assume `target_n_i` and `cur_n_i` are steady while `start_i` is high. The bench changes them only at falling edges, together with the start pulse. Random completion delays straddle the sample budget, so both the completion path and the timeout path are exercised, and each exact cycle count can be predicted.

// File: rtl/glide_pkg.sv
package glide_pkg;
  typedef enum logic [2:0] {
    G_IDLE = 3'd0,
    G_LOAD = 3'd1,
    G_SLOW = 3'd2,
    G_WRN  = 3'd3,
    G_RAMP = 3'd4,
    G_POLL = 3'd5,
    G_EXIT = 3'd6,
    G_FIN  = 3'd7
  } glide_state_e;
endpackage

// File: rtl/glide_poll_timer.sv
module glide_poll_timer #(
  parameter int IVL   = 125,
  parameter int POLLS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o,
  output logic last_o
);
  localparam int IW = (IVL > 1) ? $clog2(IVL) : 1;
  localparam int PW = (POLLS > 1) ? $clog2(POLLS) : 1;
  localparam logic [IW-1:0] IVL_END  = IW'(IVL - 1);
  localparam logic [PW-1:0] POLL_END = PW'(POLLS - 1);

  logic [IW-1:0] ivl_q;
  logic [PW-1:0] poll_q;
  logic          at_end;

  assign at_end = (ivl_q == IVL_END);
  assign tick_o = run_i && at_end;
  assign last_o = (poll_q == POLL_END);

  // spacing counter between samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ivl_q <= '0;
    else if (!run_i)  ivl_q <= '0;
    else if (at_end)  ivl_q <= '0;
    else              ivl_q <= ivl_q + 1'b1;
  end

  // number of samples already taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      poll_q <= '0;
    else if (!run_i)                 poll_q <= '0;
    else if (tick_o && !last_o)      poll_q <= poll_q + 1'b1;
  end

  generate
    if (IVL > 1) begin : g_spacing_chk
      assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && $past(run_i)) |-> !$past(tick_o));
    end
  endgenerate

  assert_poll_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (poll_q <= POLL_END));
endmodule

// File: rtl/glide_step_regs.sv
module glide_step_regs #(
  parameter int              STEP_W = 8,
  parameter logic [STEP_W-1:0] A_VAL = 8'h2B,
  parameter logic [STEP_W-1:0] B_VAL = 8'h0B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  output logic [STEP_W-1:0] step_a_o,
  output logic [STEP_W-1:0] step_b_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_a_o <= '0;
      step_b_o <= '0;
    end else if (load_i) begin
      step_a_o <= A_VAL;
      step_b_o <= B_VAL;
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(step_a_o) && $stable(step_b_o));
endmodule

// File: rtl/glide_seq.sv
module glide_seq
  import glide_pkg::*;
#(
  parameter int N_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [N_W-1:0] target_i,
  input  logic [N_W-1:0] cur_i,
  input  logic           tick_i,
  input  logic           last_i,
  input  logic           ramp_done_i,
  output glide_state_e   state_o,
  output logic [N_W-1:0] tgt_o,
  output logic           to_o
);
  glide_state_e state_q, state_d;
  logic [N_W-1:0] tgt_q;
  logic           to_q, to_d;
  logic           same_n;

  assign same_n = (target_i == cur_i);

  always_comb begin
    state_d = state_q;
    to_d    = to_q;
    unique case (state_q)
      G_IDLE: if (start_i) begin
        state_d = same_n ? G_FIN : G_LOAD;
        to_d    = 1'b0;
      end
      G_LOAD: state_d = G_SLOW;
      G_SLOW: state_d = G_WRN;
      G_WRN:  state_d = G_RAMP;
      G_RAMP: state_d = G_POLL;
      G_POLL: if (tick_i) begin
        if (ramp_done_i) state_d = G_EXIT;
        else if (last_i) begin
          state_d = G_EXIT;
          to_d    = 1'b1;
        end
      end
      G_EXIT: state_d = G_FIN;
      G_FIN:  state_d = G_IDLE;
      default: state_d = G_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= G_IDLE;
      to_q    <= 1'b0;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      to_q    <= to_d;
      if (state_q == G_IDLE && start_i) tgt_q <= target_i;
    end
  end

  assign state_o = state_q;
  assign tgt_o   = tgt_q;
  assign to_o    = to_q;

  assert_equal_fast_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == G_IDLE && start_i && same_n) |=> (state_q == G_FIN) && !to_q);

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != G_IDLE && start_i) |=> $stable(tgt_q));
endmodule

// File: rtl/ndiv_glide_ctrl.sv
module ndiv_glide_ctrl
  import glide_pkg::*;
#(
  parameter int N_W           = 8,
  parameter int STEP_W        = 8,
  parameter int STEP_A        = 'h2B,
  parameter int STEP_B        = 'h0B,
  parameter int MAX_POLLS     = 500,
  parameter int POLL_INTERVAL = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [N_W-1:0]    target_n_i,
  input  logic [N_W-1:0]    cur_n_i,
  input  logic              ramp_done_i,
  output logic [STEP_W-1:0] step_a_o,
  output logic [STEP_W-1:0] step_b_o,
  output logic              slow_en_o,
  output logic              ramp_en_o,
  output logic              n_wr_o,
  output logic [N_W-1:0]    n_val_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              busy_o
);
  localparam logic [STEP_W-1:0] A_V = STEP_W'(STEP_A);
  localparam logic [STEP_W-1:0] B_V = STEP_W'(STEP_B);

  glide_state_e   state;
  logic [N_W-1:0] tgt;
  logic           to_flag, tick, last;

  glide_seq #(.N_W(N_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .target_i(target_n_i), .cur_i(cur_n_i),
    .tick_i(tick), .last_i(last), .ramp_done_i(ramp_done_i),
    .state_o(state), .tgt_o(tgt), .to_o(to_flag)
  );

  glide_poll_timer #(.IVL(POLL_INTERVAL), .POLLS(MAX_POLLS)) tmr_i (
    .clk(clk), .rst_n(rst_n), .run_i(state == G_POLL),
    .tick_o(tick), .last_o(last)
  );

  glide_step_regs #(.STEP_W(STEP_W), .A_VAL(A_V), .B_VAL(B_V)) steps_i (
    .clk(clk), .rst_n(rst_n), .load_i(state == G_LOAD),
    .step_a_o(step_a_o), .step_b_o(step_b_o)
  );

  assign slow_en_o = (state == G_SLOW) || (state == G_WRN) ||
                     (state == G_RAMP) || (state == G_POLL);
  assign ramp_en_o = (state == G_RAMP) || (state == G_POLL);
  assign n_wr_o    = (state == G_WRN);
  assign n_val_o   = n_wr_o ? tgt : '0;
  assign done_o    = (state == G_FIN);
  assign timeout_o = (state == G_FIN) && to_flag;
  assign busy_o    = (state != G_IDLE);

  assert_step_before_slow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slow_en_o |-> (step_a_o == A_V) && (step_b_o == B_V));

  assert_wr_in_slow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    n_wr_o |-> slow_en_o && !ramp_en_o);

  assert_ramp_after_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramp_en_o) |-> $past(n_wr_o));

  assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    n_wr_o |=> !n_wr_o);

  assert_exit_together_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slow_en_o) |-> $fell(ramp_en_o));

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !slow_en_o && !ramp_en_o);

  assert_timeout_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> done_o);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: tb/ndiv_glide_ctrl_tb_top.sv
module ndiv_glide_ctrl_tb_top;
  localparam int NW  = 8;
  localparam int MP  = 6;
  localparam int IVL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NW-1:0] tgt = '0, cur = '0;
  logic rdone = 1'b0;
  logic [7:0] sa, sb;
  logic slow, ramp, nwr, done, tmo, busy;
  logic [NW-1:0] nval;

  int tests = 0, fails = 0;
  int dly = 0;
  bit never = 1'b0;
  int rcnt = 0;
  int nwr_cnt = 0, slow_cnt = 0, ord_err = 0, done_cnt = 0;
  logic [NW-1:0] last_nval = '0;
  logic prev_slow = 1'b0, prev_ramp = 1'b0, prev_nwr = 1'b0;

  always #4 clk = ~clk;

  ndiv_glide_ctrl #(.N_W(NW), .MAX_POLLS(MP), .POLL_INTERVAL(IVL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .target_n_i(tgt), .cur_n_i(cur),
    .ramp_done_i(rdone), .step_a_o(sa), .step_b_o(sb), .slow_en_o(slow),
    .ramp_en_o(ramp), .n_wr_o(nwr), .n_val_o(nval), .done_o(done),
    .timeout_o(tmo), .busy_o(busy)
  );

  // PLL gradual-change model: flag rises dly cycles after the enable
  always @(posedge clk) begin
    if (!ramp) begin
      rcnt  <= 0;
      rdone <= 1'b0;
    end else begin
      rcnt  <= rcnt + 1;
      rdone <= !never && ((rcnt + 1) >= dly);
    end
  end

  // ordering monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (slow) slow_cnt++;
      if (slow && (sa != 8'h2B || sb != 8'h0B)) ord_err++;           // R2
      if (nwr) begin
        nwr_cnt++; last_nval = nval;
        if (!slow || ramp || !prev_slow) ord_err++;                    // R3
      end
      if (ramp && !prev_ramp && !prev_nwr) ord_err++;                  // R3
      if (prev_slow && !slow && (!prev_ramp || ramp)) ord_err++;       // R7
      if (ramp && !slow) ord_err++;
      if (done) begin
        done_cnt++;
        if (slow || ramp) ord_err++;
      end
      if (tmo && !done) ord_err++;                                     // R8
      if (done && prev_done_q) ord_err++;                              // R10
    end
    prev_slow = slow; prev_ramp = ramp; prev_nwr = nwr; prev_done_q = done;
  end
  logic prev_done_q = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_samples(input int d);
    int j = (d + IVL - 1) / IVL;
    if (j < 1) j = 1;
    return j;
  endfunction

  task automatic run_op(input logic [NW-1:0] t, input logic [NW-1:0] c,
                        input int d, input bit nv, input bit poke);
    int lat = 0;
    bit exp_to;
    int exp_lat, j;
    logic got_to;
    dly = d; never = nv;
    nwr_cnt = 0; slow_cnt = 0; ord_err = 0; done_cnt = 0;
    @(negedge clk);
    tgt = t; cur = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 400) begin
      if (poke && lat == 2) begin
        start = 1'b1; tgt = t + 8'd1; cur = c;
      end else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    got_to = tmo;
    @(negedge clk);
    if (t == c) begin
      check(lat == 0, "R1 latency", lat, 0);
      check(nwr_cnt == 0 && slow_cnt == 0, "R1 untouched", nwr_cnt + slow_cnt, 0);
      check(!got_to, "R1 timeout", got_to, 0);
    end else begin
      j = exp_samples(d);
      exp_to = nv || (j > MP);
      exp_lat = exp_to ? 5 + MP * IVL : 5 + j * IVL;
      check(lat == exp_lat, exp_to ? "R8 latency" : "R6 latency", lat, exp_lat);
      check(got_to == exp_to, exp_to ? "R8 timeout flag" : "R6 timeout flag", got_to, exp_to);
      check(nwr_cnt == 1, "R4 single write", nwr_cnt, 1);
      check(last_nval == t, "R4 write value", last_nval, t);
      check(ord_err == 0, "R3 R7 ordering", ord_err, 0);
    end
    check(done_cnt == 1, poke ? "R9 single done" : "R10 single done", done_cnt, 1);
    check(!slow && !ramp && !busy, "R7 idle after", {slow, ramp, busy}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [NW-1:0] a, b;
    void'($urandom(32'h1d5eed));
    repeat (3) @(negedge clk);
    check({sa, sb, slow, ramp, nwr, nval, done, tmo, busy} == '0, "R11 reset state",
          {slow, ramp, nwr, done, tmo, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(8'd40, 8'd40, 0, 1'b0, 1'b0);          // R1
    run_op(8'd90, 8'd60, 1, 1'b0, 1'b0);          // R6 first sample
    run_op(8'd20, 8'd70, 0, 1'b1, 1'b0);          // R8 never completes
    run_op(8'd77, 8'd33, MP * IVL, 1'b0, 1'b0);   // R5 last sample succeeds
    run_op(8'd77, 8'd34, MP * IVL + 1, 1'b0, 1'b0); // R8 just misses
    run_op(8'd55, 8'd10, 7, 1'b0, 1'b1);          // R9 poke while busy
    check(last_nval == 8'd55, "R9 value kept", last_nval, 55);
    for (int i = 0; i < 24; i++) begin
      a = 8'($urandom_range(8, 255));
      b = ($urandom_range(0, 4) == 0) ? a : 8'($urandom_range(8, 255));
      run_op(a, b, int'($urandom_range(0, 24)), ($urandom_range(0, 9) == 0),
             ($urandom_range(0, 3) == 0));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule